// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Register Bank

This block is a general-purpose I/O register bank that sits on an APB slave interface. It serves up to four ports of configurable width. Each port has two registers that software can write and read back: an output value register and a direction register. A third register, read-only, shows the pin levels after synchronization. The block drives pad output values and pad output enables from these registers. Every pad input passes through a two-flop synchronizer before it can be read. The synchronized inputs of the first port also leave the block on a separate output, so that a neighbouring interrupt block can use them.

A small phase tracker follows the APB handshake. It uses three states. PH_IDLE means no transfer. PH_SETUP means a cycle with select high and enable low was seen. PH_ACCESS means a valid access phase completed. The transitions are as follows:
- Any cycle with select high and enable low moves to PH_SETUP.
- A cycle with select and enable both high, while in PH_SETUP, moves to PH_ACCESS. This is the only cycle that may commit a write or present read data.
- Every other cycle returns to PH_IDLE. This includes an enable that arrives without a preceding setup cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output value and direction register is zero, so pad_oe and pad_out are all zero.
- R2: The output value register of port p (p = 0..3) is at byte offset 0x0C*p. Its direction register is at 0x0C*p + 0x04. Both read back the last value written to them.
- R3: Bit i of port p's output value register drives pad_out[p*W+i]. Bit i of its direction register drives pad_oe[p*W+i], where 1 means output and 0 means input.
- R4: The synchronized pin levels of port p read at offset 0x50 + 4*p. A pad_in change becomes visible after the second rising clock edge that follows it, and not after the first.
- R5: porta_sync carries port 0's synchronized pin levels, with the same two-edge latency as R4.
- R6: Reads of unmapped offsets return zero. Writes to the pin-level offsets or to unmapped offsets change no register.
- R7: pready is always 1 and pslverr is always 0.
- R8: A write commits only in an access phase (psel=1, penable=1) that directly follows a setup cycle (psel=1, penable=0). An enable without a setup cycle is ignored.
- R9: prdata is zero outside a valid access phase.
- R10: paddr[1:0] is ignored, so any byte address selects the 32-bit word that contains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pad_in | input | NUM_PORTS*PORT_W | Raw pad input levels |
| pad_out | output | NUM_PORTS*PORT_W | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |
| porta_sync | output | PORT_W | Synchronized port 0 inputs |

## Verification
A wrong phase state shows up in two ways: a bare enable commits a write, or a proper access fails to commit one. Either fault appears on pad_out or pad_oe at the first clock edge after the access. A decode fault places data in the wrong port's pads, or returns non-zero data from an unmapped offset, and this can be seen on the same cycle's read. A synchronizer with the wrong depth changes porta_sync one edge early or one edge late, so the bench samples it after exactly one and after exactly two edges.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    localparam int unsigned WORD_BITS      = 32;
    localparam int unsigned WADDR_BITS     = 6;
    localparam int unsigned PAIR_STRIDE_W  = 3;   // 0x0C bytes between port pairs
    localparam int unsigned LEVEL_BASE_W   = 20;  // 0x50 byte offset
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpb_phase.sv
module gpb_phase
    import gpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_en,
    output logic rd_en
);
    apb_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = PH_IDLE;
        unique case (phase_q)
            PH_IDLE, PH_ACCESS: begin
                if (psel && !penable) phase_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (psel && penable)       phase_d = PH_ACCESS;
                else if (psel && !penable) phase_d = PH_SETUP;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (phase_q)
            PH_SETUP: begin
                wr_en = psel && penable && pwrite;
                rd_en = psel && penable && !pwrite;
            end
            default: begin
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        endcase
    end

    // R8
    access_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (phase_q == PH_ACCESS));

    // R8
    no_bare_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_SETUP) |-> !(wr_en || rd_en));
endmodule

// File: rtl/gpb_port.sv
module gpb_port
    import gpb_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WADDR_BITS-1:0] waddr,
    input  logic [WORD_BITS-1:0]  wdata,
    input  logic [W-1:0]          pins,
    output logic [W-1:0]          value_q,
    output logic [W-1:0]          dir_q,
    output logic [W-1:0]          level_q,
    output logic [WORD_BITS-1:0]  rd_word
);
    localparam logic [WADDR_BITS-1:0] VALUE_W = WADDR_BITS'(PAIR_STRIDE_W * IDX);
    localparam logic [WADDR_BITS-1:0] DIR_W   = WADDR_BITS'(PAIR_STRIDE_W * IDX + 1);
    localparam logic [WADDR_BITS-1:0] LEVEL_W = WADDR_BITS'(LEVEL_BASE_W + IDX);

    logic hit_value, hit_dir, hit_level;
    logic we_value, we_dir;

    assign hit_value = (waddr == VALUE_W);
    assign hit_dir   = (waddr == DIR_W);
    assign hit_level = (waddr == LEVEL_W);
    assign we_value  = wr_en && hit_value;
    assign we_dir    = wr_en && hit_dir;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            dir_q   <= '0;
        end else begin
            if (we_value) value_q <= wdata[W-1:0];
            if (we_dir)   dir_q   <= wdata[W-1:0];
        end
    end

    gpb_sync #(.W(W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins),
        .q     (level_q)
    );

    always_comb begin
        rd_word = '0;
        if (hit_value)      rd_word[W-1:0] = value_q;
        else if (hit_dir)   rd_word[W-1:0] = dir_q;
        else if (hit_level) rd_word[W-1:0] = level_q;
    end

    // R2
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_value |=> $stable(value_q));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dir |=> $stable(dir_q));

    // R2
    value_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_value |=> (value_q == $past(wdata[W-1:0])));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 32
) (
    input  logic                        pclk,
    input  logic                        presetn,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [7:0]                  paddr,
    input  logic [31:0]                 pwdata,
    output logic [31:0]                 prdata,
    output logic                        pready,
    output logic                        pslverr,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0]           porta_sync
);
    logic                  wr_en, rd_en;
    logic [WADDR_BITS-1:0] waddr;
    logic [1:0]            unused_byte_sel;
    logic [WORD_BITS-1:0]  rd_words [NUM_PORTS];
    logic [PORT_W-1:0]     levels   [NUM_PORTS];
    logic [WORD_BITS-1:0]  rd_any;

    assign waddr           = paddr[7:2];
    assign unused_byte_sel = paddr[1:0];
    assign pready          = 1'b1;
    assign pslverr         = 1'b0;

    gpb_phase i_phase (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpb_port #(.W(PORT_W), .IDX(p)) i_port (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_en   (wr_en),
            .waddr   (waddr),
            .wdata   (pwdata),
            .pins    (pad_in[p*PORT_W +: PORT_W]),
            .value_q (pad_out[p*PORT_W +: PORT_W]),
            .dir_q   (pad_oe[p*PORT_W +: PORT_W]),
            .level_q (levels[p]),
            .rd_word (rd_words[p])
        );
    end

    assign porta_sync = levels[0];

    always_comb begin
        rd_any = '0;
        for (int p = 0; p < NUM_PORTS; p++) rd_any = rd_any | rd_words[p];
    end

    assign prdata = rd_en ? rd_any : '0;

    // R9
    idle_bus_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !psel |-> (prdata == '0));

    // R3
    oe_reset_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(presetn) |-> (pad_oe == '0));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int NP = 4;
    localparam int W  = 32;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic [NP*W-1:0] pad_in = '0;
    logic [NP*W-1:0] pad_out, pad_oe;
    logic [W-1:0]  porta_sync;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 pclk = ~pclk;

    gpio_bank #(.NUM_PORTS(NP), .PORT_W(W)) i_gpio_bank (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .porta_sync(porta_sync)
    );

    // {is_write, byte address, data or expected read}
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hA5A5_0001},
        {1'b1, 8'h04, 32'h0000_FFFF},
        {1'b1, 8'h0C, 32'h1234_5678},
        {1'b1, 8'h10, 32'hFFFF_0000},
        {1'b1, 8'h18, 32'hCAFE_F00D},
        {1'b1, 8'h1C, 32'h0F0F_0F0F},
        {1'b1, 8'h24, 32'h8000_0001},
        {1'b1, 8'h28, 32'hFFFF_FFFF},
        {1'b0, 8'h00, 32'hA5A5_0001},
        {1'b0, 8'h04, 32'h0000_FFFF},
        {1'b0, 8'h0C, 32'h1234_5678},
        {1'b0, 8'h1C, 32'h0F0F_0F0F},
        {1'b0, 8'h24, 32'h8000_0001},
        {1'b0, 8'h28, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic [NP*W-1:0] exp_out, exp_oe, pins;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        apb_read(8'h04, rd);
        check("R1 dir read", rd, 32'h0);
        // R7
        check("R7 pready", pready, 1'b1);
        check("R7 pslverr", pslverr, 1'b0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][40]) apb_write(VEC[k][39:32], VEC[k][31:0]);
            else begin
                apb_read(VEC[k][39:32], rd);
                check("R2 readback", rd, VEC[k][31:0]);
            end
        end

        exp_out = {32'h8000_0001, 32'hCAFE_F00D, 32'h1234_5678, 32'hA5A5_0001};
        exp_oe  = {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hFFFF_0000, 32'h0000_FFFF};
        check("R3 pad_out", pad_out, exp_out);
        check("R3 pad_oe", pad_oe, exp_oe);

        // R9 idle bus returns zero
        @(negedge pclk);
        paddr = 8'h00;
        #1 check("R9 idle prdata", prdata, 32'h0);

        // R8 bare access phase without setup
        @(negedge pclk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'hFFFF_FFFF;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R8 bare write ignored", pad_out[31:0], 32'hA5A5_0001);

        // R6 writes to level window and unmapped words
        apb_write(8'h50, 32'hDEAD_BEEF);
        apb_write(8'h08, 32'h1111_1111);
        apb_write(8'h2C, 32'h2222_2222);
        apb_write(8'h60, 32'h3333_3333);
        check("R6 pads unchanged", pad_out, exp_out);
        check("R6 oe unchanged", pad_oe, exp_oe);
        apb_read(8'h08, rd);
        check("R6 unmapped 0x08", rd, 32'h0);
        apb_read(8'h60, rd);
        check("R6 unmapped 0x60", rd, 32'h0);
        apb_read(8'h50, rd);
        check("R6 level not written", rd, 32'h0);

        // R10 low address bits ignored
        apb_write(8'h0E, 32'h0BAD_CAFE);
        apb_read(8'h0D, rd);
        check("R10 byte alias", rd, 32'h0BAD_CAFE);
        check("R10 pads port1", pad_out[63:32], 32'h0BAD_CAFE);

        // R4 / R5 synchronizer latency
        pins = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
        @(negedge pclk);
        pad_in = pins;
        @(negedge pclk);
        check("R5 one edge old", porta_sync, 32'h0);
        @(negedge pclk);
        check("R5 two edges new", porta_sync, 32'h1111_0001);
        for (int p = 0; p < NP; p++) begin
            apb_read(8'(8'h50 + 4 * p), rd);
            check("R4 level read", rd, pins[p*W +: W]);
        end

        // R1 reset again clears everything
        @(negedge pclk);
        presetn = 1'b0;
        @(negedge pclk);
        presetn = 1'b1;
        check("R1 reset oe", pad_oe, '0);
        check("R1 reset out", pad_out, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule